// File: doc/BRIEF.md
# Cartridge ROM Bank Mapper

This block turns a 24-bit CPU bus address into a physical address in a cartridge ROM of up to 8 MB. The ROM is viewed as a row of 1 MB chunks. Four bank-select registers each name one chunk. Each register serves one quarter of the high bank range, `$C0-$FF`, where every bank is a linear 64 KB slice of the chosen chunk.

The same register also governs one quarter of the low ranges, `$00-$3F` and `$80-$BF`. In those banks only the upper half of each bank (offsets `$8000-$FFFF`) is ROM, so 32 banks make up one 1 MB chunk. A follow flag in each register picks how that low quarter is mapped. With the flag set, it uses the chunk the register names for the high range. With the flag clear, it keeps its fixed default chunk. This lets software point the high banks into the second 4 MB while the low banks stay in the first 4 MB.

The decode is purely combinational from address to output. Only the registers are clocked.

Top module: `rom_bank_mapper`

## Requirements
- R1: While reset is held and after it is released, register n holds chunk n with its follow flag clear.
- R2: For banks `$C0-$FF`, the quarter index is n = bank[5:4]. `rom_sel` is 1 and `rom_addr` = {chunk of register n, bank[3:0], offset[15:0]}.
- R3: For banks `$00-$3F` and `$80-$BF` with offset[15] = 1, the quarter index is n = {bank[7], bank[5]}, so `$00-$1F`→0, `$20-$3F`→1, `$80-$9F`→2 and `$A0-$BF`→3. `rom_sel` is 1 and `rom_addr` = {effective chunk, bank[4:0], offset[14:0]}.
- R4: In a low-range quarter whose register has the follow flag (write-data bit 7) set, the effective chunk is the register's programmed chunk.
- R5: In a low-range quarter whose register has the follow flag clear, the effective chunk is n, whatever chunk the register holds.
- R6: `rom_sel` is 0 for banks `$40-$7F` at any offset, and for low-range banks at offsets `$0000-$7FFF`.
- R7: When `reg_we` is high at a rising clock edge, register `reg_idx` takes its chunk from `reg_wdata[2:0]` and its follow flag from `reg_wdata[7]`. Bits 6:3 are ignored. Other registers are unchanged, and the new mapping applies from that edge on.
- R8: With follow flags clear, the high banks can reach chunks 4-7 (the last 4 MB) while the low banks still address chunks 0-3 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register being written (quarter index) |
| reg_wdata | input | 8 | Write data: bit 7 follow flag, bits 2:0 chunk |
| cpu_addr | input | 24 | CPU bus address (bank in bits 23:16) |
| rom_sel | output | 1 | ROM window hit |
| rom_addr | output | 23 | Physical ROM byte address, valid when `rom_sel` is 1 |

## Verification
The bench builds the block with the default chunk width of 3, which gives an 8 MB ROM space of eight 1 MB chunks. At this size, all 256 banks can be swept at both edges of the ROM and non-ROM halves of a bank, plus an offset in the middle, for every register configuration tried. The configurations cover the reset layout, all-follow, no-follow with high chunks in the top 4 MB, and mixed flags. Every write also carries nonzero junk in the ignored bits.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   localparam int REGION_CNT  = 4;
   localparam int REGION_W    = 2;
   localparam int BANK_W      = 8;
   localparam int OFFSET_W    = 16;
   localparam int LOW_OFF_W   = 15;
   localparam int LOW_BANK_W  = 5;
   localparam int HIGH_BANK_W = 4;
   localparam int CHUNK_OFF_W = 20;

   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_LOW  = 2'd1,
      WIN_HIGH = 2'd2
   } win_e;

   typedef struct packed {
      win_e                win;
      logic [REGION_W-1:0] region;
   } decode_t;
endpackage

// File: rtl/rbm_cfg_regs.sv
module rbm_cfg_regs
   import rbm_pkg::*;
#(
   parameter int CHUNK_W    = 3,
   parameter int DATA_W     = 8,
   parameter int FOLLOW_BIT = 7
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 we,
   input  logic [REGION_W-1:0]                  idx,
   input  logic [DATA_W-1:0]                    wdata,
   output logic [REGION_CNT-1:0][CHUNK_W-1:0]   chunk_o,
   output logic [REGION_CNT-1:0]                follow_o
);
   logic [REGION_CNT-1:0][CHUNK_W-1:0] chunk_q;
   logic [REGION_CNT-1:0]              follow_q;

   for (genvar n = 0; n < REGION_CNT; n++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chunk_q[n]  <= CHUNK_W'(n);
            follow_q[n] <= 1'b0;
         end else if (we && idx == REGION_W'(n)) begin
            chunk_q[n]  <= wdata[CHUNK_W-1:0];
            follow_q[n] <= wdata[FOLLOW_BIT];
         end
      end
   end

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^wdata;

   assign chunk_o  = chunk_q;
   assign follow_o = follow_q;

   AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (chunk_q[$past(idx)] == $past(wdata[CHUNK_W-1:0]))
             && (follow_q[$past(idx)] == $past(wdata[FOLLOW_BIT]))); // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(chunk_q) && $stable(follow_q)); // R7
endmodule

// File: rtl/rbm_window_decode.sv
module rbm_window_decode
   import rbm_pkg::*;
(
   input  logic [BANK_W+OFFSET_W-1:0] addr,
   output decode_t                    dec_o
);
   logic [BANK_W-1:0] bank;
   logic              upper_half;

   assign bank       = addr[BANK_W+OFFSET_W-1:OFFSET_W];
   assign upper_half = addr[OFFSET_W-1];

   always_comb begin
      dec_o.win    = WIN_NONE;
      dec_o.region = '0;
      if (bank[7:6] == 2'b11) begin
         dec_o.win    = WIN_HIGH;
         dec_o.region = bank[5:4];
      end else if (!bank[6] && upper_half) begin
         dec_o.win    = WIN_LOW;
         dec_o.region = {bank[7], bank[5]};
      end
   end
endmodule

// File: rtl/rbm_addr_compose.sv
module rbm_addr_compose
   import rbm_pkg::*;
#(
   parameter int CHUNK_W = 3,
   localparam int ROM_AW = CHUNK_W + CHUNK_OFF_W
) (
   input  logic [BANK_W+OFFSET_W-1:0]         addr,
   input  decode_t                            dec,
   input  logic [REGION_CNT-1:0][CHUNK_W-1:0] chunk,
   input  logic [REGION_CNT-1:0]              follow,
   output logic                               hit_o,
   output logic [ROM_AW-1:0]                  rom_addr_o
);
   logic [REGION_CNT-1:0][CHUNK_W-1:0] low_chunk;

   for (genvar n = 0; n < REGION_CNT; n++) begin : g_low
      assign low_chunk[n] = follow[n] ? chunk[n] : CHUNK_W'(n);
   end

   always_comb begin
      hit_o      = 1'b0;
      rom_addr_o = '0;
      unique case (dec.win)
         WIN_HIGH: begin
            hit_o      = 1'b1;
            rom_addr_o = {chunk[dec.region],
                          addr[OFFSET_W+HIGH_BANK_W-1:OFFSET_W],
                          addr[OFFSET_W-1:0]};
         end
         WIN_LOW: begin
            hit_o      = 1'b1;
            rom_addr_o = {low_chunk[dec.region],
                          addr[OFFSET_W+LOW_BANK_W-1:OFFSET_W],
                          addr[LOW_OFF_W-1:0]};
         end
         default: begin
            hit_o      = 1'b0;
            rom_addr_o = '0;
         end
      endcase
   end
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
   import rbm_pkg::*;
#(
   parameter int CHUNK_W    = 3,
   parameter int DATA_W     = 8,
   parameter int FOLLOW_BIT = 7,
   localparam int ADDR_W    = BANK_W + OFFSET_W,
   localparam int ROM_AW    = CHUNK_W + CHUNK_OFF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [REGION_W-1:0] reg_idx,
   input  logic [DATA_W-1:0]   reg_wdata,
   input  logic [ADDR_W-1:0]   cpu_addr,
   output logic                rom_sel,
   output logic [ROM_AW-1:0]   rom_addr
);
   if (CHUNK_W < REGION_W || CHUNK_W > 7) begin : g_bad_chunk_w
      $error("rom_bank_mapper: CHUNK_W must lie in %0d..7", REGION_W);
   end
   if (FOLLOW_BIT < CHUNK_W || FOLLOW_BIT >= DATA_W) begin : g_bad_follow_bit
      $error("rom_bank_mapper: FOLLOW_BIT must sit above the chunk field inside DATA_W");
   end

   logic [REGION_CNT-1:0][CHUNK_W-1:0] cfg_chunk;
   logic [REGION_CNT-1:0]              cfg_follow;
   decode_t                            dec;

   rbm_cfg_regs #(
      .CHUNK_W   (CHUNK_W),
      .DATA_W    (DATA_W),
      .FOLLOW_BIT(FOLLOW_BIT)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .idx     (reg_idx),
      .wdata   (reg_wdata),
      .chunk_o (cfg_chunk),
      .follow_o(cfg_follow)
   );

   rbm_window_decode i_decode (
      .addr (cpu_addr),
      .dec_o(dec)
   );

   rbm_addr_compose #(
      .CHUNK_W(CHUNK_W)
   ) i_compose (
      .addr      (cpu_addr),
      .dec       (dec),
      .chunk     (cfg_chunk),
      .follow    (cfg_follow),
      .hit_o     (rom_sel),
      .rom_addr_o(rom_addr)
   );

   AST_GAP_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[23:22] == 2'b01 || (!cpu_addr[22] && !cpu_addr[15])) |-> !rom_sel); // R6
   AST_HIGH_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[23:22] == 2'b11) |->
         rom_sel && rom_addr[ROM_AW-1:CHUNK_OFF_W] == cfg_chunk[cpu_addr[21:20]]); // R2
   AST_LOW_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_addr[22] && cpu_addr[15] && !cfg_follow[{cpu_addr[23], cpu_addr[21]}]) |->
         rom_sel && rom_addr[ROM_AW-1:CHUNK_OFF_W] == CHUNK_W'({cpu_addr[23], cpu_addr[21]})); // R5
   AST_LOW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_addr[22] && cpu_addr[15] && cfg_follow[{cpu_addr[23], cpu_addr[21]}]) |->
         rom_sel && rom_addr[ROM_AW-1:CHUNK_OFF_W] == cfg_chunk[{cpu_addr[23], cpu_addr[21]}]); // R4
endmodule

// File: tb/test_rom_bank_mapper.sv
module test_rom_bank_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_idx = '0;
   logic [7:0]  reg_wdata = '0;
   logic [23:0] cpu_addr = '0;
   logic        rom_sel;
   logic [22:0] rom_addr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [2:0] m_chunk [4];
   logic       m_follow [4];

   always #5 clk = ~clk;

   rom_bank_mapper i_rom_bank_mapper (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (reg_we),
      .reg_idx  (reg_idx),
      .reg_wdata(reg_wdata),
      .cpu_addr (cpu_addr),
      .rom_sel  (rom_sel),
      .rom_addr (rom_addr)
   );

   task automatic write_reg(input int n, input logic [2:0] c, input logic f);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_idx   = 2'(n);
      reg_wdata = {f, 4'(n * 3 + 5), c};
      @(negedge clk);
      reg_we    = 1'b0;
      reg_wdata = 8'hFF;
      m_chunk[n]  = c;
      m_follow[n] = f;
   endtask

   task automatic check_addr(input logic [23:0] a, input string tag);
      logic [7:0]  bank;
      logic        exp_sel;
      logic [22:0] exp_addr;
      logic [1:0]  n;
      logic [2:0]  c;
      bank     = a[23:16];
      exp_sel  = 1'b0;
      exp_addr = '0;
      if (bank[7:6] == 2'b11) begin
         n        = bank[5:4];
         exp_sel  = 1'b1;
         exp_addr = 23'(m_chunk[n]) * 23'h100000 + 23'(bank[3:0]) * 23'h10000 + 23'(a[15:0]);
      end else if (bank[6] == 1'b0 && a[15]) begin
         n        = {bank[7], bank[5]};
         c        = m_follow[n] ? m_chunk[n] : 3'(n);
         exp_sel  = 1'b1;
         exp_addr = 23'(c) * 23'h100000 + 23'(bank[4:0]) * 23'h8000 + 23'(a[14:0]);
      end
      cpu_addr = a;
      #1;
      total++;
      if (rom_sel !== exp_sel || (exp_sel && rom_addr !== exp_addr)) begin
         bad++;
         $display("FAIL %s addr=%06h sel=%0b/%0b rom_addr=%06h expected %06h",
                  tag, a, rom_sel, exp_sel, rom_addr, exp_addr);
      end
   endtask

   task automatic sweep(input string tag);
      logic [15:0] offs [5];
      offs = '{16'h0000, 16'h7FFF, 16'h8000, 16'hA5C3, 16'hFFFF};
      for (int b = 0; b < 256; b++) begin
         for (int k = 0; k < 5; k++) begin
            check_addr({8'(b), offs[k]}, tag);
         end
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int n = 0; n < 4; n++) begin
         m_chunk[n]  = 3'(n);
         m_follow[n] = 1'b0;
      end
      // R1: reset layout visible while reset is held
      #3;
      check_addr(24'hC01234, "R1 in reset high");
      check_addr(24'hA18000, "R1 in reset low");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 R2 R3 R5 R6: full sweep of reset layout
      sweep("R1/R2/R3/R6 reset layout");
      // R8 R5: high banks into last 4 MB, low banks stay default
      for (int n = 0; n < 4; n++) write_reg(n, 3'(4 + n), 1'b0);
      sweep("R8/R5 high in top 4MB");
      // R4 R7: every quarter follows, reversed chunks
      for (int n = 0; n < 4; n++) write_reg(n, 3'(7 - n), 1'b1);
      sweep("R4/R7 follow all");
      // R7: single write leaves others unchanged
      write_reg(2, 3'd1, 1'b0);
      sweep("R7 single write mixed");
      // R4 R5: alternating flags, duplicated chunks
      write_reg(0, 3'd6, 1'b0);
      write_reg(1, 3'd6, 1'b1);
      write_reg(3, 3'd0, 1'b1);
      sweep("R4/R5 mixed flags");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule